// File: doc/BRIEF.md
# Battery Alert and Status Logic

This block sits beside a battery fuel-gauge datapath. Each time a new measurement is strobed in, it compares the cell voltage and the state of charge against thresholds that software programs. When any enabled condition is met, it latches a global alert bit and drives an active-low interrupt output. The output stays low until software writes the alert bit back to zero. Sticky cause flags tell the handler why the interrupt fired. The handler services the condition, then clears the flags and the global bit with ordinary register writes.

Five causes are supported:
- a falling crossing of a programmable empty level of charge;
- a whole-percent change of charge relative to a captured reference;
- the cell voltage above the top of a programmable window;
- the cell voltage below the bottom of that window;
- an external voltage-reset event, whose flag is always recorded but whose interrupt has its own enable.

Configuration and flags are reached through a 16-bit word port. A write takes effect only when both byte enables are set.

Top module: `alrt_ctrl`

## Requirements
- R1: Any enabled cause sets the alert bit, which is bit 5 of the control word, and drives `alert_n` low one clock later. The bit and the pin hold until a full write to the control word puts 0 in bit 5. A hardware set in the same cycle as that write wins over the clear.
- R2: The empty threshold field is control bits [4:0]. The threshold in percent equals 32 minus the field, so field 0 means 32% and field 31 means 1%.
- R3: The low-charge cause, flag bit 12, fires on a sample whose whole-percent charge is below the threshold when the previous sample was at or above it. It never fires on a rising crossing, and never on the first sample after reset.
- R4: The window word holds the minimum in bits [15:8] and the maximum in bits [7:0], each in 20 mV steps, compared against `vcell[15:8]`. A sample with code > max sets flag bit 9 and raises the alert. A sample with code < min sets flag bit 10 and raises the alert. This repeats on every sample while the condition holds.
- R5: With control bit 6 set, a sample whose whole percent (`soc[15:8]`) differs from the reference sets flag bit 13 and raises the alert. No new change fires while bit 13 is set. Clearing bit 13 captures the latest percent as the new reference. While bit 6 is 0, the reference follows every sample.
- R6: The flag word has this layout: bit 14 reset-alert enable, 13 change, 12 low charge, 11 voltage reset, 10 voltage low, 9 voltage high, 8 reset indicator. Bit 15 and bits [7:0] always read 0. The word resets to 0x0100.
- R7: A pulse on `vrst_evt` always sets flag bit 11. It raises the alert only when flag bit 14 is 1.
- R8: The control word resets to 0x971C and the window word resets to 0x00FF. Control bit 7 (sleep request) is stored but neither clears nor blocks any alert or flag.
- R9: A write with `wr_be` other than 2'b11 changes no register.
- R10: The word addresses are 0 for control, 1 for window and 2 for flags. Address 3 reads 0. Control bits [15:8] are a free compensation byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_vld | input | 1 | One-cycle strobe: new vcell/soc sample |
| vcell | input | 16 | Cell voltage, 78.125 uV per LSB |
| soc | input | 16 | State of charge, upper byte in whole percent |
| vrst_evt | input | 1 | One-cycle voltage-reset event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 16 | Write data |
| wr_be | input | 2 | Byte enables; only 2'b11 writes |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 16 | Read data (combinational) |
| alert_n | output | 1 | Active-low latched interrupt |

## Verification
The bench builds the block with its default parameters:
- 16-bit voltage and charge words;
- an 8-bit fraction byte;
- 8-bit window fields;
- a 5-bit empty field.

With these values the window codes are the voltage's upper byte, so the extreme window settings 0x00 and 0xFF, and codes just above, below and equal to each bound, are all reachable. The empty field spans its whole range, so the 1% and 32% end points of the threshold are driven directly. A behavioural model recomputes every register and the pin each clock. It covers falling and rising charge crossings, re-arming of the change alert, the split voltage-reset gating and rejected partial writes.

// File: rtl/alrt_pkg.sv
package alrt_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_VWIN = 2'd1,
        REG_FLAG = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // control word fields
    localparam int CTL_SLEEP = 7;
    localparam int CTL_CHGEN = 6;
    localparam int CTL_ALERT = 5;

    // flag word fields
    localparam int FL_ENVR = 14;
    localparam int FL_CHG  = 13;
    localparam int FL_LOW  = 12;
    localparam int FL_VR   = 11;
    localparam int FL_VL   = 10;
    localparam int FL_VH   = 9;
    localparam int FL_RI   = 8;

    localparam logic [DATA_W-1:0] CTRL_RST  = 16'h971C;
    localparam logic [DATA_W-1:0] VWIN_RST  = 16'h00FF;
    localparam logic [DATA_W-1:0] FLAG_RST  = 16'h0100;
    localparam logic [DATA_W-1:0] FLAG_MASK = 16'h7F00;

    typedef struct packed {
        logic low;
        logic chg;
        logic vh;
        logic vl;
        logic vr;
    } evt_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] vwin;
        logic [DATA_W-1:0] flags;
    } regs_t;
endpackage

// File: rtl/alrt_volt_cmp.sv
module alrt_volt_cmp #(
    parameter int VOLT_W = 16,
    parameter int TH_W   = 8
) (
    input  logic              meas_vld,
    input  logic [VOLT_W-1:0] vcell,
    input  logic [TH_W-1:0]   win_max,
    input  logic [TH_W-1:0]   win_min,
    output logic              v_hi,
    output logic              v_lo
);
    localparam int SHIFT = VOLT_W - TH_W;

    logic [TH_W-1:0] code;

    always_comb begin
        code = TH_W'(vcell >> SHIFT);
        v_hi = meas_vld && (code > win_max);
        v_lo = meas_vld && (code < win_min);
    end
endmodule

// File: rtl/alrt_soc_track.sv
module alrt_soc_track #(
    parameter int SOC_W  = 16,
    parameter int FRAC_W = 8,
    parameter int ATHD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_vld,
    input  logic [SOC_W-1:0]  soc,
    input  logic [ATHD_W-1:0] athd,
    input  logic              chg_en,
    input  logic              chg_flag,
    input  logic              chg_clr,
    output logic              low_evt,
    output logic              chg_evt
);
    localparam int PCT_W = SOC_W - FRAC_W;
    localparam logic [PCT_W-1:0] TOP = PCT_W'(1 << ATHD_W);

    typedef struct packed {
        logic [PCT_W-1:0] prev;
        logic             prev_vld;
        logic [PCT_W-1:0] ref_pct;
        logic             ref_vld;
    } trk_t;

    trk_t s_d, s_q;
    logic [PCT_W-1:0] pct;
    logic [PCT_W-1:0] thr;

    always_comb begin
        pct     = PCT_W'(soc >> FRAC_W);
        thr     = TOP - PCT_W'(athd);
        low_evt = meas_vld && s_q.prev_vld && (s_q.prev >= thr) && (pct < thr);
        chg_evt = meas_vld && chg_en && !chg_flag && s_q.ref_vld
                  && (pct != s_q.ref_pct);

        s_d = s_q;
        if (chg_clr) begin
            s_d.ref_pct = meas_vld ? pct : s_q.prev;
            s_d.ref_vld = meas_vld || s_q.prev_vld;
        end else if (meas_vld && (!s_q.ref_vld || !chg_en)) begin
            s_d.ref_pct = pct;
            s_d.ref_vld = 1'b1;
        end
        if (meas_vld) begin
            s_d.prev     = pct;
            s_d.prev_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: after a low event the stored sample lies below the threshold used
    assert_low_falling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        low_evt |=> (s_q.prev < $past(thr)));

    // R5: a change event leaves the new sample different from the held reference
    assert_chg_differs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_evt |=> (s_q.ref_pct != s_q.prev));
endmodule

// File: rtl/alrt_ctrl.sv
module alrt_ctrl
    import alrt_pkg::*;
#(
    parameter int VOLT_W = 16,
    parameter int SOC_W  = 16,
    parameter int FRAC_W = 8,
    parameter int TH_W   = 8,
    parameter int ATHD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_vld,
    input  logic [VOLT_W-1:0] vcell,
    input  logic [SOC_W-1:0]  soc,
    input  logic              vrst_evt,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_be,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              alert_n
);
    regs_t r_d, r_q;
    evt_t  ev;
    logic  full_wr;
    logic  chg_clr;
    logic  raise;
    logic  v_hi, v_lo;

    assign full_wr = wr_en && (wr_be == 2'b11);
    assign chg_clr = full_wr && (reg_sel_e'(wr_addr) == REG_FLAG)
                     && r_q.flags[FL_CHG] && !wr_data[FL_CHG];

    alrt_volt_cmp #(.VOLT_W(VOLT_W), .TH_W(TH_W)) u_vcmp (
        .meas_vld (meas_vld),
        .vcell    (vcell),
        .win_max  (r_q.vwin[TH_W-1:0]),
        .win_min  (r_q.vwin[2*TH_W-1:TH_W]),
        .v_hi     (v_hi),
        .v_lo     (v_lo)
    );

    alrt_soc_track #(.SOC_W(SOC_W), .FRAC_W(FRAC_W), .ATHD_W(ATHD_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .meas_vld (meas_vld),
        .soc      (soc),
        .athd     (r_q.ctrl[ATHD_W-1:0]),
        .chg_en   (r_q.ctrl[CTL_CHGEN]),
        .chg_flag (r_q.flags[FL_CHG]),
        .chg_clr  (chg_clr),
        .low_evt  (ev.low),
        .chg_evt  (ev.chg)
    );

    assign ev.vh = v_hi;
    assign ev.vl = v_lo;
    assign ev.vr = vrst_evt;

    always_comb begin
        raise = ev.low || ev.chg || ev.vh || ev.vl || (ev.vr && r_q.flags[FL_ENVR]);
        r_d = r_q;
        if (full_wr) begin
            case (reg_sel_e'(wr_addr))
                REG_CTRL: r_d.ctrl  = wr_data;
                REG_VWIN: r_d.vwin  = wr_data;
                REG_FLAG: r_d.flags = wr_data & FLAG_MASK;
                default:  ;
            endcase
        end
        if (ev.low) r_d.flags[FL_LOW] = 1'b1;
        if (ev.chg) r_d.flags[FL_CHG] = 1'b1;
        if (ev.vh)  r_d.flags[FL_VH]  = 1'b1;
        if (ev.vl)  r_d.flags[FL_VL]  = 1'b1;
        if (ev.vr)  r_d.flags[FL_VR]  = 1'b1;
        if (raise)  r_d.ctrl[CTL_ALERT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl  <= CTRL_RST;
            r_q.vwin  <= VWIN_RST;
            r_q.flags <= FLAG_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_sel_e'(rd_addr))
            REG_CTRL: rd_data = r_q.ctrl;
            REG_VWIN: rd_data = r_q.vwin;
            REG_FLAG: rd_data = r_q.flags;
            default:  rd_data = '0;
        endcase
    end

    assign alert_n = ~r_q.ctrl[CTL_ALERT];

    // R1: alert bit holds unless software writes the control word
    assert_alert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctrl[CTL_ALERT] && !(full_wr && reg_sel_e'(wr_addr) == REG_CTRL))
        |=> !alert_n);

    // R7: voltage-reset flag is recorded regardless of its enable
    assert_vr_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vrst_evt |=> r_q.flags[FL_VR]);

    // R7: with enable clear and no other cause the pin is not asserted
    assert_vr_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vrst_evt && !r_q.flags[FL_ENVR] && !ev.low && !ev.chg && !ev.vh && !ev.vl
         && !r_q.ctrl[CTL_ALERT] && !(full_wr && reg_sel_e'(wr_addr) == REG_CTRL))
        |=> alert_n);

    // R4: an over-window sample leaves its flag set
    assert_volt_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v_hi |=> r_q.flags[FL_VH]);

    // R9: partial-byte writes leave the window word unchanged
    assert_partial_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be != 2'b11) |=> $stable(r_q.vwin));
endmodule

// File: tb/tb_alrt_ctrl.sv
module tb_alrt_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_vld = 1'b0;
    logic [15:0] vcell = 16'h9000;
    logic [15:0] soc = 16'h0000;
    logic        vrst_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0000;
    logic [1:0]  wr_be = 2'b11;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        alert_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string phase = "R8";

    always #5 clk = ~clk;

    alrt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .vcell(vcell), .soc(soc),
        .vrst_evt(vrst_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data), .alert_n(alert_n)
    );

    // behavioural reference model
    logic [15:0] m_ctrl, m_win, m_flag;
    int m_prev, m_ref, p, v, thr;
    bit m_pv, m_rv, lo, ch, vh, vl, chen, clr, wr, rise;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 16'h971C; m_win = 16'h00FF; m_flag = 16'h0100;
            m_prev = 0; m_ref = 0; m_pv = 0; m_rv = 0;
        end else begin
            p = int'(soc) / 256;
            v = int'(vcell) / 256;
            thr = 32 - int'(m_ctrl[4:0]);
            chen = m_ctrl[6];
            lo = meas_vld && m_pv && (m_prev >= thr) && (p < thr);
            ch = meas_vld && chen && !m_flag[13] && m_rv && (p != m_ref);
            vh = meas_vld && (v > int'(m_win[7:0]));
            vl = meas_vld && (v < int'(m_win[15:8]));
            rise = lo || ch || vh || vl || (vrst_evt && m_flag[14]);
            wr = wr_en && (wr_be == 2'b11);
            clr = wr && (wr_addr == 2'd2) && m_flag[13] && !wr_data[13];
            if (wr) begin
                if (wr_addr == 2'd0) m_ctrl = wr_data;
                if (wr_addr == 2'd1) m_win = wr_data;
                if (wr_addr == 2'd2) m_flag = wr_data & 16'h7F00;
            end
            if (lo) m_flag[12] = 1'b1;
            if (ch) m_flag[13] = 1'b1;
            if (vh) m_flag[9] = 1'b1;
            if (vl) m_flag[10] = 1'b1;
            if (vrst_evt) m_flag[11] = 1'b1;
            if (rise) m_ctrl[5] = 1'b1;
            if (clr) begin
                m_ref = meas_vld ? p : m_prev;
                m_rv = meas_vld || m_pv;
            end else if (meas_vld && (!m_rv || !chen)) begin
                m_ref = p; m_rv = 1'b1;
            end
            if (meas_vld) begin m_prev = p; m_pv = 1'b1; end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] exp_rd;
            case (rd_addr)
                2'd0: exp_rd = m_ctrl;
                2'd1: exp_rd = m_win;
                2'd2: exp_rd = m_flag;
                default: exp_rd = 16'h0000;
            endcase
            checks++;
            if (rd_data !== exp_rd || alert_n !== ~m_ctrl[5]) begin
                fails++;
                $display("FAIL %s model: rd_data=%h exp=%h alert_n=%b exp=%b",
                         phase, rd_data, exp_rd, alert_n, ~m_ctrl[5]);
            end
        end
    end

    task automatic idle();
        @(posedge clk); #2;
        meas_vld = 1'b0; vrst_evt = 1'b0; wr_en = 1'b0; wr_be = 2'b11;
    endtask

    task automatic sample(input logic [15:0] vv, input logic [15:0] ss);
        @(posedge clk); #2;
        meas_vld = 1'b1; vcell = vv; soc = ss;
        idle();
    endtask

    task automatic wreg(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        idle();
    endtask

    task automatic pulse_vr();
        @(posedge clk); #2;
        vrst_evt = 1'b1;
        idle();
    endtask

    task automatic rchk(input string tag, input logic [1:0] a, input logic [15:0] exp);
        rd_addr = a;
        @(negedge clk);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s addr %0d: got %h expected %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic pchk(input string tag, input logic exp);
        @(negedge clk);
        checks++;
        if (alert_n !== exp) begin
            fails++;
            $display("FAIL %s alert_n: got %b expected %b", tag, alert_n, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // reset state
        phase = "R8";
        rchk("R8", 2'd0, 16'h971C);
        rchk("R8", 2'd1, 16'h00FF);
        rchk("R6", 2'd2, 16'h0100);
        pchk("R1", 1'b1);

        // R3 falling crossing of default 4%
        phase = "R3";
        sample(16'h9000, 16'h0500);
        rchk("R3", 2'd2, 16'h0100);
        sample(16'h9000, 16'h0300);
        rchk("R3", 2'd2, 16'h1100);
        pchk("R1", 1'b0);
        wreg(2'd2, 16'h0100, 2'b11);
        pchk("R1", 1'b0);
        wreg(2'd0, 16'h971C, 2'b11);
        pchk("R1", 1'b1);
        sample(16'h9000, 16'h0200);
        sample(16'h9000, 16'h0600);
        rchk("R3", 2'd2, 16'h0100);
        pchk("R3", 1'b1);

        // R2 threshold end points
        phase = "R2";
        wreg(2'd0, 16'h971F, 2'b11);
        sample(16'h9000, 16'h0100);
        rchk("R2", 2'd2, 16'h0100);
        sample(16'h9000, 16'h0000);
        rchk("R2", 2'd2, 16'h1100);
        wreg(2'd2, 16'h0100, 2'b11);
        wreg(2'd0, 16'h9700, 2'b11);
        sample(16'h9000, 16'h2000);
        sample(16'h9000, 16'h1F00);
        rchk("R2", 2'd2, 16'h1100);
        wreg(2'd2, 16'h0100, 2'b11);
        wreg(2'd0, 16'h971C, 2'b11);

        // R9 partial writes
        phase = "R9";
        wreg(2'd0, 16'h0000, 2'b01);
        rchk("R9", 2'd0, 16'h971C);
        wreg(2'd1, 16'h1234, 2'b10);
        rchk("R9", 2'd1, 16'h00FF);

        // R4 voltage window
        phase = "R4";
        wreg(2'd1, 16'h90A8, 2'b11);
        sample(16'hA900, 16'h3000);
        rchk("R4", 2'd2, 16'h0300);
        pchk("R4", 1'b0);
        wreg(2'd2, 16'h0100, 2'b11);
        wreg(2'd0, 16'h971C, 2'b11);
        sample(16'h8F00, 16'h3000);
        rchk("R4", 2'd2, 16'h0500);
        wreg(2'd2, 16'h0100, 2'b11);
        wreg(2'd0, 16'h971C, 2'b11);
        sample(16'hA800, 16'h3000);
        sample(16'h9000, 16'h3000);
        rchk("R4", 2'd2, 16'h0100);
        pchk("R4", 1'b1);

        // R7 voltage reset gating
        phase = "R7";
        pulse_vr();
        rchk("R7", 2'd2, 16'h0900);
        pchk("R7", 1'b1);
        wreg(2'd2, 16'h4000, 2'b11);
        pulse_vr();
        rchk("R7", 2'd2, 16'h4800);
        pchk("R7", 1'b0);
        wreg(2'd2, 16'h0000, 2'b11);
        wreg(2'd0, 16'h971C, 2'b11);

        // R5 change alert and re-arm
        phase = "R5";
        sample(16'h9000, 16'h3280);
        wreg(2'd0, 16'h975C, 2'b11);
        sample(16'h9000, 16'h32FF);
        rchk("R5", 2'd2, 16'h0000);
        sample(16'h9000, 16'h3100);
        rchk("R5", 2'd2, 16'h2000);
        pchk("R5", 1'b0);
        sample(16'h9000, 16'h2F00);
        wreg(2'd2, 16'h0000, 2'b11);
        wreg(2'd0, 16'h975C, 2'b11);
        sample(16'h9000, 16'h2F00);
        rchk("R5", 2'd2, 16'h0000);
        pchk("R5", 1'b1);
        sample(16'h9000, 16'h3000);
        rchk("R5", 2'd2, 16'h2000);

        // R8 sleep bit keeps alerts
        phase = "R8";
        wreg(2'd0, 16'h97FC, 2'b11);
        pchk("R8", 1'b0);
        rchk("R8", 2'd0, 16'h97FC);
        rchk("R8", 2'd2, 16'h2000);

        // R10 / R6 map and reserved bits
        phase = "R10";
        rchk("R10", 2'd3, 16'h0000);
        phase = "R6";
        wreg(2'd2, 16'hFFFF, 2'b11);
        rchk("R6", 2'd2, 16'h7F00);

        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule